// File: doc/BRIEF.md
# Crypto Engine Register Wrapper

This block is a bus-slave register file that sits between a 32-bit memory-mapped bus and a block-cipher engine. The engine needs a key-setup phase before it can process data. A 256-byte window holds three groups of four 32-bit words: the key, the input block and the captured result. Four further words serve as control and status. Software fills the key and input words. A write to a control word starts the engine, and the wrapper turns that write into a one-cycle strobe. Software then polls a sticky status word and clears it by writing to the same address.

The engine's result is valid only during the cycle in which it signals done. The wrapper therefore copies the result into its own registers at that moment, and bus reads return the copy. Each access is a one-cycle select and is acknowledged on the following cycle. Read data arrives together with the acknowledge.

Top module: `crypt_regif`

## Requirements
- R1: An access is acknowledged exactly one cycle after a cycle with `bus_sel` high, and only when `bus_addr[31:8]` equals the window base. Accesses outside the window are not acknowledged, return zero and have no effect.
- R2: Byte offsets 0x00–0x0C hold the key words and 0x10–0x1C hold the input words. Both groups can be written and read back. Word 0 of each group (the lowest offset) maps to bits 127:96 of `eng_key` / `eng_din`, and word 3 maps to bits 31:0.
- R3: A write to offset 0x30 with `bus_wdata[0]`=1 drives `eng_load` high for exactly the one cycle after the write. A write there with bit 0 = 0 gives no pulse.
- R4: A write to offset 0x38 with `bus_wdata[0]`=1 drives `eng_kload` high for exactly the one cycle after the write. A write there with bit 0 = 0 gives no pulse.
- R5: A cycle with `eng_done` high sets a sticky flag, and a read of offset 0x34 then returns 0x00000001 (0x00000000 when clear). A cycle with `eng_kdone` high does the same for offset 0x3C.
- R6: Any write to 0x34 clears the done flag, and any write to 0x3C clears the key-done flag. If the engine's done arrives in the same cycle as the clearing write, the flag stays set.
- R7: `eng_dout` is captured when `eng_done` is high. Offsets 0x20–0x2C return the captured words, word 0 being bits 127:96. Later changes of `eng_dout` have no effect on them.
- R8: Reads of unmapped in-window offsets (0x40–0xFF and addresses with nonzero bits 1:0) return zero. Writes to these offsets, to the result words and to the status words other than by clearing have no effect on any stored word.
- R9: After reset, all stored words and flags read zero, and `bus_ack`, `eng_load` and `eng_kload` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access select, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| bus_ack | output | 1 | Acknowledge, one cycle after select |
| eng_key | output | 128 | Key toward the engine |
| eng_din | output | 128 | Input block toward the engine |
| eng_load | output | 1 | One-cycle start strobe |
| eng_kload | output | 1 | One-cycle key-setup strobe |
| eng_dout | input | 128 | Engine result, valid while done is high |
| eng_done | input | 1 | Engine result ready |
| eng_kdone | input | 1 | Engine key setup finished |

## Verification
A wrong stored word or a wrong word-to-lane mapping shows on `eng_key`/`eng_din` in the cycle after the write, and also on the next read of that offset. A flag that fails to stick or fails to clear shows on the very next status read. A missed capture edge shows as the engine's placeholder value on the next read of a result word. A bad decode shows up in the 64-offset read sweep taken right after reset and in the writes to unmapped offsets, as a nonzero word or a missing acknowledge one cycle after the select.

// File: rtl/crypt_regif_pkg.sv
package crypt_regif_pkg;

    localparam int GRP_WORDS = 4;
    localparam int GRP_IDX_W = 2;
    localparam int WIN_BITS  = 8;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_KEY,
        RG_DIN,
        RG_DOUT,
        RG_LOAD,
        RG_DONE,
        RG_KLOAD,
        RG_KDONE
    } region_e;

    typedef struct packed {
        logic                 hit;
        region_e              region;
        logic [GRP_IDX_W-1:0] idx;
    } dec_t;

    // slot = byte offset bits 7:2, lsb = byte offset bits 1:0
    function automatic region_e slot_region(logic [5:0] slot, logic [1:0] lsb);
        region_e r;
        r = RG_NONE;
        if (lsb == 2'b00 && slot[5:4] == 2'b00) begin
            case (slot[3:2])
                2'd0: r = RG_KEY;
                2'd1: r = RG_DIN;
                2'd2: r = RG_DOUT;
                default: begin
                    case (slot[1:0])
                        2'd0:    r = RG_LOAD;
                        2'd1:    r = RG_DONE;
                        2'd2:    r = RG_KLOAD;
                        default: r = RG_KDONE;
                    endcase
                end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/crypt_regif_decode.sv
module crypt_regif_decode
    import crypt_regif_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_FF00
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    localparam logic [ADDR_W-WIN_BITS-1:0] BASE_HI = BASE_ADDR[ADDR_W-1:WIN_BITS];

    always_comb begin
        dec.hit    = (addr[ADDR_W-1:WIN_BITS] == BASE_HI);
        dec.region = dec.hit ? slot_region(addr[WIN_BITS-1:2], addr[1:0]) : RG_NONE;
        dec.idx    = addr[3:2];
    end

endmodule

// File: rtl/crypt_word_bank.sv
module crypt_word_bank #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    cap_en,
    input  logic [DATA_W*WORDS-1:0] cap_data,
    output logic [DATA_W*WORDS-1:0] blk
);

    localparam int BLK_W = DATA_W * WORDS;

    // word i sits in the lane starting at the top of the block
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        localparam int HI = BLK_W - 1 - i * DATA_W;
        always_ff @(posedge clk) begin
            if (rst) begin
                blk[HI -: DATA_W] <= '0;
            end else if (cap_en) begin
                blk[HI -: DATA_W] <= cap_data[HI -: DATA_W];
            end else if (wr_en && (int'(wr_idx) == i)) begin
                blk[HI -: DATA_W] <= wr_data;
            end
        end
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !cap_en) |=> $stable(blk)); // R8

endmodule

// File: rtl/crypt_sticky_flag.sv
module crypt_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    AST_FLAG_SET:   assert property (@(posedge clk) disable iff (rst)
        set |=> flag); // R5
    AST_FLAG_HOLD:  assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag); // R6

endmodule

// File: rtl/crypt_regif.sv
module crypt_regif
    import crypt_regif_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_FF00
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic                          bus_ack,
    output logic [DATA_W*GRP_WORDS-1:0]   eng_key,
    output logic [DATA_W*GRP_WORDS-1:0]   eng_din,
    output logic                          eng_load,
    output logic                          eng_kload,
    input  logic [DATA_W*GRP_WORDS-1:0]   eng_dout,
    input  logic                          eng_done,
    input  logic                          eng_kdone
);

    localparam int BLK_W = DATA_W * GRP_WORDS;

    dec_t             dec;
    logic             wr_acc, rd_acc;
    logic             key_we, din_we;
    logic             load_fire, kload_fire;
    logic             done_clr, kdone_clr;
    logic             done_flag, kdone_flag;
    logic [BLK_W-1:0] out_blk;
    logic [DATA_W-1:0] rd_word;

    function automatic logic [DATA_W-1:0] pick_word(logic [BLK_W-1:0] b,
                                                    logic [GRP_IDX_W-1:0] i);
        return b[BLK_W - 1 - int'(i) * DATA_W -: DATA_W];
    endfunction

    crypt_regif_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .dec  (dec)
    );

    always_comb begin
        wr_acc     = bus_sel && bus_wr && dec.hit;
        rd_acc     = bus_sel && !bus_wr && dec.hit;
        key_we     = wr_acc && (dec.region == RG_KEY);
        din_we     = wr_acc && (dec.region == RG_DIN);
        load_fire  = wr_acc && (dec.region == RG_LOAD)  && bus_wdata[0];
        kload_fire = wr_acc && (dec.region == RG_KLOAD) && bus_wdata[0];
        done_clr   = wr_acc && (dec.region == RG_DONE);
        kdone_clr  = wr_acc && (dec.region == RG_KDONE);
    end

    crypt_word_bank #(.DATA_W(DATA_W), .WORDS(GRP_WORDS)) u_key_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (key_we),
        .wr_idx   (dec.idx),
        .wr_data  (bus_wdata),
        .cap_en   (1'b0),
        .cap_data ('0),
        .blk      (eng_key)
    );

    crypt_word_bank #(.DATA_W(DATA_W), .WORDS(GRP_WORDS)) u_din_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (din_we),
        .wr_idx   (dec.idx),
        .wr_data  (bus_wdata),
        .cap_en   (1'b0),
        .cap_data ('0),
        .blk      (eng_din)
    );

    crypt_word_bank #(.DATA_W(DATA_W), .WORDS(GRP_WORDS)) u_out_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (1'b0),
        .wr_idx   (dec.idx),
        .wr_data  (bus_wdata),
        .cap_en   (eng_done),
        .cap_data (eng_dout),
        .blk      (out_blk)
    );

    crypt_sticky_flag u_done_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (eng_done),
        .clr  (done_clr),
        .flag (done_flag)
    );

    crypt_sticky_flag u_kdone_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (eng_kdone),
        .clr  (kdone_clr),
        .flag (kdone_flag)
    );

    always_comb begin
        rd_word = '0;
        case (dec.region)
            RG_KEY:   rd_word = pick_word(eng_key, dec.idx);
            RG_DIN:   rd_word = pick_word(eng_din, dec.idx);
            RG_DOUT:  rd_word = pick_word(out_blk, dec.idx);
            RG_DONE:  rd_word = {{(DATA_W-1){1'b0}}, done_flag};
            RG_KDONE: rd_word = {{(DATA_W-1){1'b0}}, kdone_flag};
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            eng_load  <= 1'b0;
            eng_kload <= 1'b0;
        end else begin
            bus_ack   <= bus_sel && dec.hit;
            bus_rdata <= rd_acc ? rd_word : '0;
            eng_load  <= load_fire;
            eng_kload <= kload_fire;
        end
    end

    AST_ACK_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> $past(bus_sel && (bus_addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]))); // R1
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_ack |-> (bus_rdata == '0)); // R1
    AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        eng_load |-> $past(bus_sel && bus_wr && bus_wdata[0] &&
                           (bus_addr == BASE_ADDR + 32'h30))); // R3
    AST_KLOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        eng_kload |-> $past(bus_sel && bus_wr && bus_wdata[0] &&
                            (bus_addr == BASE_ADDR + 32'h38))); // R4
    AST_OUT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> (out_blk == $past(eng_dout))); // R7

endmodule

// File: tb/crypt_regif_bench.sv
module crypt_regif_bench;

    localparam logic [31:0]  BASE    = 32'hFFFF_FF00;
    localparam logic [127:0] GARBAGE = {4{32'hDEAD_BEEF}};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [31:0]  bus_addr = '0, bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_ack;
    logic [127:0] eng_key, eng_din;
    logic         eng_load, eng_kload;
    logic [127:0] eng_dout = GARBAGE;
    logic         eng_done = 1'b0, eng_kdone = 1'b0;

    int checks = 0, failures = 0;
    logic last_ack, last_load, last_kload;
    logic [31:0] rd;
    logic [31:0] kw [4];
    logic [31:0] dw [4];
    logic [127:0] exp_out;

    always #2 clk = ~clk;

    crypt_regif u_crypt_regif (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .eng_key(eng_key), .eng_din(eng_din),
        .eng_load(eng_load), .eng_kload(eng_kload), .eng_dout(eng_dout),
        .eng_done(eng_done), .eng_kdone(eng_kdone)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr_evt(input logic [31:0] a, input logic [31:0] d,
                              input logic dn, input logic kdn, input logic [127:0] dv);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        eng_done = dn; eng_kdone = kdn;
        if (dn) eng_dout = dv;
        @(negedge clk);
        last_ack = bus_ack; last_load = eng_load; last_kload = eng_kload;
        bus_sel = 1'b0; bus_wr = 1'b0;
        eng_done = 1'b0; eng_kdone = 1'b0; eng_dout = GARBAGE;
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        bus_wr_evt(a, d, 1'b0, 1'b0, '0);
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        last_ack = bus_ack; d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic eng_finish(input logic kind_key, input logic [127:0] dv);
        @(negedge clk);
        if (kind_key) eng_kdone = 1'b1;
        else begin eng_done = 1'b1; eng_dout = dv; end
        @(negedge clk);
        eng_done = 1'b0; eng_kdone = 1'b0; eng_dout = GARBAGE;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 ack after reset", {31'b0, bus_ack}, 32'd0);
        chk("R9 load after reset", {31'b0, eng_load}, 32'd0);
        chk("R9 kload after reset", {31'b0, eng_kload}, 32'd0);
        chk("R9 key after reset", eng_key[31:0] | eng_key[127:96], 32'd0);

        // R9 / R8 / R1: every word of the window reads zero and is acknowledged
        for (int s = 0; s < 64; s++) begin
            bus_read(BASE + 32'(s * 4), rd);
            chk("R9 reset sweep read", rd, 32'd0);
            chk("R1 ack in window", {31'b0, last_ack}, 32'd1);
        end

        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 4; i++) begin
                kw[i] = 32'h0101_0101 * 32'(r * 8 + i + 1) ^ 32'h8000_0000;
                dw[i] = 32'h0013_0507 * 32'(r * 8 + i + 3);
                bus_write(BASE + 32'(i * 4), kw[i]);
                bus_write(BASE + 32'h10 + 32'(i * 4), dw[i]);
            end
            for (int i = 0; i < 4; i++) begin
                bus_read(BASE + 32'(i * 4), rd);
                chk("R2 key readback", rd, kw[i]);
                bus_read(BASE + 32'h10 + 32'(i * 4), rd);
                chk("R2 din readback", rd, dw[i]);
                chk("R2 key lane", eng_key[127 - i * 32 -: 32], kw[i]);
                chk("R2 din lane", eng_din[127 - i * 32 -: 32], dw[i]);
            end
            bus_write(BASE + 32'h30, 32'h0000_0002);
            chk("R3 no pulse on bit0=0", {31'b0, last_load}, 32'd0);
            bus_read(BASE + 32'h34, rd);
            chk("R5 done clear before run", rd, 32'd0);
            bus_write(BASE + 32'h30, 32'h0000_0001);
            chk("R3 load pulse high", {31'b0, last_load}, 32'd1);
            @(negedge clk);
            chk("R3 load pulse one cycle", {31'b0, eng_load}, 32'd0);
            repeat (6) @(negedge clk);
            for (int i = 0; i < 4; i++)
                exp_out[127 - i * 32 -: 32] = kw[i] ^ dw[i] ^ (32'h1111_1111 * 32'(i + 1));
            eng_finish(1'b0, exp_out);
            bus_read(BASE + 32'h34, rd);
            chk("R5 done latched", rd, 32'd1);
            bus_read(BASE + 32'h3C, rd);
            chk("R5 kdone untouched", rd, 32'd0);
            for (int i = 0; i < 4; i++) begin
                bus_read(BASE + 32'h20 + 32'(i * 4), rd);
                chk("R7 captured result", rd, exp_out[127 - i * 32 -: 32]);
            end
            bus_write(BASE + 32'h34, 32'h0000_0001);
            bus_read(BASE + 32'h34, rd);
            chk("R6 done cleared", rd, 32'd0);
        end

        // R4: key setup strobe and flag
        bus_write(BASE + 32'h38, 32'h0000_0000);
        chk("R4 no kload on bit0=0", {31'b0, last_kload}, 32'd0);
        bus_write(BASE + 32'h38, 32'h0000_0001);
        chk("R4 kload pulse high", {31'b0, last_kload}, 32'd1);
        chk("R4 load stays low", {31'b0, last_load}, 32'd0);
        @(negedge clk);
        chk("R4 kload pulse one cycle", {31'b0, eng_kload}, 32'd0);
        eng_finish(1'b1, '0);
        bus_read(BASE + 32'h3C, rd);
        chk("R5 kdone latched", rd, 32'd1);
        // R6: set in the same cycle as the clearing write wins
        bus_wr_evt(BASE + 32'h3C, 32'h1, 1'b0, 1'b1, '0);
        bus_read(BASE + 32'h3C, rd);
        chk("R6 kdone collision stays set", rd, 32'd1);
        bus_write(BASE + 32'h3C, 32'h1);
        bus_read(BASE + 32'h3C, rd);
        chk("R6 kdone cleared", rd, 32'd0);
        bus_wr_evt(BASE + 32'h34, 32'h1, 1'b1, 1'b0, exp_out);
        bus_read(BASE + 32'h34, rd);
        chk("R6 done collision stays set", rd, 32'd1);
        bus_write(BASE + 32'h34, 32'h1);

        // R7: result words ignore later engine output and bus writes (R8)
        eng_dout = {4{32'h5555_AAAA}};
        bus_write(BASE + 32'h24, 32'h1234_5678);
        bus_read(BASE + 32'h24, rd);
        chk("R8 result word not writable", rd, exp_out[95:64]);
        chk("R7 result holds", rd, exp_out[95:64]);

        // R8: unmapped and misaligned offsets
        bus_write(BASE + 32'h44, 32'hFFFF_FFFF);
        bus_read(BASE + 32'h44, rd);
        chk("R8 unmapped read zero", rd, 32'd0);
        bus_write(BASE + 32'h01, 32'hCAFE_F00D);
        bus_read(BASE + 32'h00, rd);
        chk("R8 misaligned write ignored", rd, kw[0]);
        bus_read(BASE + 32'h01, rd);
        chk("R8 misaligned read zero", rd, 32'd0);
        chk("R1 misaligned acked", {31'b0, last_ack}, 32'd1);

        // R1: outside the window
        bus_write(32'hFFFF_FE30, 32'h1);
        chk("R1 no ack outside window", {31'b0, last_ack}, 32'd0);
        chk("R1 no strobe outside window", {31'b0, last_load}, 32'd0);
        bus_write(32'hFFFF_FE00, 32'h7777_7777);
        bus_read(32'hFFFF_FE00, rd);
        chk("R1 read outside window zero", rd, 32'd0);
        chk("R1 read outside not acked", {31'b0, last_ack}, 32'd0);
        bus_read(BASE, rd);
        chk("R1 outside write no effect", rd, kw[0]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule